// File: doc/BRIEF.md
# Stereo Offset Calibration Sequencer

This block sits at the output of a stereo converter's digital datapath and runs its offset calibration. A functional reset input, active low, idles the whole datapath: the sample outputs stay at zero and the busy flag is raised immediately, without waiting for a clock. When reset is released, the block counts frame periods on a frame-rate strobe. It keeps the busy flag high for a calibration window whose length depends on the speed mode and on whether the frame clock is produced locally (master) or received (slave).

In the last part of the window the block sums the incoming samples of each channel separately. The mean of that sum becomes the channel's stored offset. After calibration every strobed sample has its channel's offset subtracted and is saturated to the sample width. Corrected samples are presented only once a second, later frame count has been reached. A source-select input says whether the measurement uses the live inputs or the internal common-mode level. The block sends that choice to the analog side and freezes it once calibration ends.

Top module: `offset_cal_seq`

## Requirements
- R1: While `rst_n` is low, `cal_busy_o` is 1 and `data_ok_o`, `cal_src_o`, `out_vld_o`, `out_l_o` and `out_r_o` are all 0. This takes effect asynchronously when `rst_n` falls.
- R2: A frame period is a low-to-high transition of `lrck_i` seen at two consecutive clock edges. Only transitions after the internal reset release count, and that release comes two clocks after `rst_n` rises.
- R3: With master timing (`slave_i`=0), `cal_busy_o` falls at the clock edge that registers frame period CAL_FRAMES (normal speed, `dbl_speed_i`=0) or 2*CAL_FRAMES (double speed, `dbl_speed_i`=1).
- R4: With master timing, `data_ok_o` rises at the edge that registers frame period VALID_FRAMES (normal speed) or 2*VALID_FRAMES (double speed), and then stays high until reset.
- R5: With `slave_i`=1, both limits in R3 and R4 are one frame period larger.
- R6: Each channel's offset is the sum of the samples strobed while the frame count lies in [L-2^AVG_LOG2, L-1], where L is the calibration limit. The sum is arithmetically shifted right by AVG_LOG2. The offset does not change after `cal_busy_o` falls.
- R7: One clock after a cycle with `smp_stb_i`=1, `out_vld_o` pulses and each output holds its sample minus its channel's offset, provided `data_ok_o` was 1. If `data_ok_o` was 0, the strobe loads 0 into both outputs and `out_vld_o` stays 0.
- R8: A corrected value above 2^(DW-1)-1 is output as 2^(DW-1)-1, and a value below -2^(DW-1) is output as -2^(DW-1) (two's complement).
- R9: While `cal_busy_o` is 1 and the block is out of reset, `cal_src_o` takes the value of `zcal_i` one clock later (1 = analog inputs, 0 = common-mode level). After calibration it holds its value.
- R10: A new reset, asserted at any point including mid-calibration, clears the frame count and both offset sums, so the next sequence starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Functional reset, active low, asynchronous assertion |
| lrck_i | input | 1 | Frame-rate strobe, synchronous to clk |
| dbl_speed_i | input | 1 | 1 doubles both frame limits |
| slave_i | input | 1 | 1 adds one frame to both limits |
| zcal_i | input | 1 | Measurement source select |
| smp_stb_i | input | 1 | One-cycle sample strobe for both channels |
| smp_l_i | input | DW | Left sample, two's complement |
| smp_r_i | input | DW | Right sample, two's complement |
| cal_busy_o | output | 1 | Calibration in progress |
| cal_src_o | output | 1 | Source choice sent to the analog side |
| data_ok_o | output | 1 | Output data valid window reached |
| out_vld_o | output | 1 | Corrected sample pair present |
| out_l_o | output | DW | Corrected left sample |
| out_r_o | output | DW | Corrected right sample |

## Verification
The hardest case to reach from the ports is a corrected sample that saturates. This needs a stored offset that is nonzero and opposite in sign to a full-scale input, and the offset only exists after a full calibration window. The stimulus therefore calibrates against a negative offset on one channel and a positive offset on the other. It then strobes alternating full-scale maximum and minimum samples once the window is over, so each channel clips in one direction and passes the other. A second hard case is a reset asserted in the middle of a window. This is reached by cutting the sequence short halfway through and rerunning with slave timing and a source select that toggles every frame.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

  // Sequencer state seen by both channel datapaths.
  typedef struct packed {
    logic busy;   // calibration window open
    logic win;    // accumulation part of the window
    logic ok;     // output data may be presented
  } seq_flags_t;

endpackage

// File: rtl/ocal_rst_sync.sv
module ocal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic s0_q;
  logic s1_q;

  // Assert at once, release after two clock edges.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_n_o = s1_q;

endmodule

// File: rtl/ocal_frame_seq.sv
module ocal_frame_seq
  import ocal_pkg::*;
#(
  parameter int CAL_FRAMES   = 8704,
  parameter int VALID_FRAMES = 8960,
  parameter int AVG_LOG2     = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lrck_i,
  input  logic       dbl_i,
  input  logic       slave_i,
  output seq_flags_t flags_o
);

  localparam int CNT_W = $clog2(2 * VALID_FRAMES + 2) + 1;
  localparam logic [CNT_W-1:0] CAL_N = CNT_W'(CAL_FRAMES);
  localparam logic [CNT_W-1:0] CAL_D = CNT_W'(2 * CAL_FRAMES);
  localparam logic [CNT_W-1:0] VAL_N = CNT_W'(VALID_FRAMES);
  localparam logic [CNT_W-1:0] VAL_D = CNT_W'(2 * VALID_FRAMES);
  localparam logic [CNT_W-1:0] AVG_N = CNT_W'(2 ** AVG_LOG2);

  logic             lrck_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic [CNT_W-1:0] cal_lim;
  logic [CNT_W-1:0] val_lim;
  logic [CNT_W-1:0] win_lo;
  logic             rise;

  always_comb begin
    cal_lim = (dbl_i ? CAL_D : CAL_N) + {{(CNT_W-1){1'b0}}, slave_i};
    val_lim = (dbl_i ? VAL_D : VAL_N) + {{(CNT_W-1){1'b0}}, slave_i};
    win_lo  = cal_lim - AVG_N;
  end

  // Count frame-period starts; saturate at the valid limit.
  always_comb begin
    rise   = lrck_i & ~lrck_q;
    cnt_en = rise && (cnt_q < val_lim);
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      lrck_q <= lrck_i;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  always_comb begin
    flags_o.busy = (cnt_q < cal_lim);
    flags_o.win  = (cnt_q >= win_lo) && (cnt_q < cal_lim);
    flags_o.ok   = (cnt_q >= val_lim);
  end

endmodule

// File: rtl/ocal_chan.sv
module ocal_chan #(
  parameter int DW       = 24,
  parameter int AVG_LOG2 = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_i,
  input  logic [DW-1:0] sample_i,
  input  logic          win_i,
  input  logic          ok_i,
  output logic [DW-1:0] off_o,
  output logic [DW-1:0] dat_o,
  output logic          vld_o
);

  localparam int ACC_W = DW + AVG_LOG2;
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_MAX = {1'b1, {(DW-1){1'b0}}};

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;
  logic [DW:0]      diff;
  logic [DW-1:0]    sat;
  logic [DW-1:0]    dat_d;
  logic             dat_en;
  logic             vld_d;

  always_comb begin
    acc_en = stb_i & win_i;
    acc_d  = acc_q + {{AVG_LOG2{sample_i[DW-1]}}, sample_i};
  end

  // Arithmetic right shift by AVG_LOG2, truncated to DW: the top DW bits.
  assign off_o = acc_q[AVG_LOG2 +: DW];

  always_comb begin
    diff = {sample_i[DW-1], sample_i} - {off_o[DW-1], off_o};
    if (diff[DW] != diff[DW-1]) begin
      sat = diff[DW] ? NEG_MAX : POS_MAX;
    end else begin
      sat = diff[DW-1:0];
    end
    dat_en = stb_i;
    dat_d  = ok_i ? sat : '0;
    vld_d  = stb_i & ok_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      dat_o <= '0;
      vld_o <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
      end
      if (dat_en) begin
        dat_o <= dat_d;
      end
      vld_o <= vld_d;
    end
  end

endmodule

// File: rtl/offset_cal_seq.sv
module offset_cal_seq
  import ocal_pkg::*;
#(
  parameter int DW           = 24,
  parameter int CAL_FRAMES   = 8704,
  parameter int VALID_FRAMES = 8960,
  parameter int AVG_LOG2     = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrck_i,
  input  logic          dbl_speed_i,
  input  logic          slave_i,
  input  logic          zcal_i,
  input  logic          smp_stb_i,
  input  logic [DW-1:0] smp_l_i,
  input  logic [DW-1:0] smp_r_i,
  output logic          cal_busy_o,
  output logic          cal_src_o,
  output logic          data_ok_o,
  output logic          out_vld_o,
  output logic [DW-1:0] out_l_o,
  output logic [DW-1:0] out_r_o
);

  localparam int NCH = 2;

  logic                    rst_int_n;
  seq_flags_t              flags;
  logic [NCH-1:0][DW-1:0]  smp_bus;
  logic [NCH-1:0][DW-1:0]  dat_bus;
  logic [NCH-1:0]          vld_bus;
  logic [NCH*DW-1:0]       off_flat;
  logic                    src_q;
  logic                    src_d;
  logic                    src_en;

  ocal_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  ocal_frame_seq #(
    .CAL_FRAMES   (CAL_FRAMES),
    .VALID_FRAMES (VALID_FRAMES),
    .AVG_LOG2     (AVG_LOG2)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lrck_i  (lrck_i),
    .dbl_i   (dbl_speed_i),
    .slave_i (slave_i),
    .flags_o (flags)
  );

  assign smp_bus = {smp_r_i, smp_l_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DW-1:0] off_w;
    ocal_chan #(
      .DW       (DW),
      .AVG_LOG2 (AVG_LOG2)
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .stb_i    (smp_stb_i),
      .sample_i (smp_bus[g]),
      .win_i    (flags.win),
      .ok_i     (flags.ok),
      .off_o    (off_w),
      .dat_o    (dat_bus[g]),
      .vld_o    (vld_bus[g])
    );
    assign off_flat[g*DW +: DW] = off_w;
  end

  // Source select follows the input only while calibrating.
  always_comb begin
    src_en = flags.busy;
    src_d  = zcal_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      src_q <= 1'b0;
    end else if (src_en) begin
      src_q <= src_d;
    end
  end

  assign cal_busy_o = flags.busy;
  assign data_ok_o  = flags.ok;
  assign cal_src_o  = src_q;
  assign out_vld_o  = &vld_bus;
  assign out_l_o    = dat_bus[0];
  assign out_r_o    = dat_bus[1];

endmodule

// File: rtl/offset_cal_seq_chk.sv
module offset_cal_seq_chk #(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cal_busy_o,
  input logic          cal_src_o,
  input logic          data_ok_o,
  input logic          out_vld_o,
  input logic [DW-1:0] out_l_o,
  input logic [DW-1:0] out_r_o,
  input logic [2*DW-1:0] off_flat
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |-> (cal_busy_o && !data_ok_o && !cal_src_o && !out_vld_o
                && out_l_o == '0 && out_r_o == '0));

  assert_busy_no_reraise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy_o |=> !cal_busy_o);

  assert_ok_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok_o |-> !cal_busy_o);

  assert_ok_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_ok_o |=> data_ok_o);

  assert_offset_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy_o |=> $stable(off_flat));

  assert_vld_needs_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld_o |-> data_ok_o);

  assert_src_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_busy_o |=> $stable(cal_src_o));

endmodule

bind offset_cal_seq offset_cal_seq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cal_busy_o (cal_busy_o),
  .cal_src_o  (cal_src_o),
  .data_ok_o  (data_ok_o),
  .out_vld_o  (out_vld_o),
  .out_l_o    (out_l_o),
  .out_r_o    (out_r_o),
  .off_flat   (off_flat)
);

// File: tb/offset_cal_seq_test.sv
`timescale 1ns/1ps
module offset_cal_seq_test;

  localparam int DW   = 24;
  localparam int CALF = 40;
  localparam int VALF = 44;
  localparam int NAVG = 3;
  localparam int FR   = 16;
  localparam longint PMAX = 64'sd8388607;
  localparam longint NMAX = -64'sd8388608;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0, dbl = 1'b0, slv = 1'b0, zcal = 1'b0, stb = 1'b0;
  logic [DW-1:0] sl = '0, sr = '0;
  logic busy, src, ok, vld;
  logic [DW-1:0] ol, orr;

  always #2 clk = ~clk;

  offset_cal_seq #(.DW(DW), .CAL_FRAMES(CALF), .VALID_FRAMES(VALF), .AVG_LOG2(NAVG)) uut (
    .clk(clk), .rst_n(rst_n), .lrck_i(lrck), .dbl_speed_i(dbl), .slave_i(slv),
    .zcal_i(zcal), .smp_stb_i(stb), .smp_l_i(sl), .smp_r_i(sr),
    .cal_busy_o(busy), .cal_src_o(src), .data_ok_o(ok), .out_vld_o(vld),
    .out_l_o(ol), .out_r_o(orr));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0, restart_run = 1'b0, zcal_toggle = 1'b0;
  int gk = 0;
  int base_l = 0, base_r = 0;

  // Behavioural reference state.
  int     m_rel = 0, m_cnt = 0;
  bit     m_prev = 1'b1, m_edge = 1'b0, m_src = 1'b0, m_vld = 1'b0;
  longint m_acc_l = 0, m_acc_r = 0, m_out_l = 0, m_out_r = 0;
  bit     m_sat_l = 1'b0, m_sat_r = 1'b0;

  function automatic int cal_lim();
    return (dbl ? 2 * CALF : CALF) + (slv ? 1 : 0);
  endfunction
  function automatic int val_lim();
    return (dbl ? 2 * VALF : VALF) + (slv ? 1 : 0);
  endfunction
  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint clip(input longint d, output bit s);
    s = (d > PMAX) || (d < NMAX);
    if (d > PMAX) return PMAX;
    if (d < NMAX) return NMAX;
    return d;
  endfunction

  always @(posedge clk) begin
    m_edge = 1'b0;
    if (!rst_n) begin
      m_rel = 0; m_cnt = 0; m_prev = 1'b1; m_src = 1'b0; m_vld = 1'b0;
      m_acc_l = 0; m_acc_r = 0; m_out_l = 0; m_out_r = 0;
    end else if (m_rel < 2) begin
      m_rel++;  // internal reset still held (R2)
    end else begin
      m_vld = stb && (m_cnt >= val_lim());
      if (stb) begin
        if (m_cnt >= val_lim()) begin
          m_out_l = clip(sx(sl) - (m_acc_l >>> NAVG), m_sat_l);
          m_out_r = clip(sx(sr) - (m_acc_r >>> NAVG), m_sat_r);
        end else begin
          m_out_l = 0; m_out_r = 0; m_sat_l = 0; m_sat_r = 0;
        end
        // R6: sum over the last 2^NAVG frame counts of the window
        if (m_cnt < cal_lim() && m_cnt >= cal_lim() - (1 << NAVG)) begin
          m_acc_l += sx(sl);
          m_acc_r += sx(sr);
        end
      end
      if (m_cnt < cal_lim()) m_src = zcal;
      if (lrck && !m_prev && m_cnt < val_lim()) begin
        m_cnt++;
        m_edge = 1'b1;
      end
      m_prev = lrck;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk("R1", "busy", 32'(busy), 32'd1);
        chk("R1", "ok", 32'(ok), 32'd0);
        chk("R1", "src", 32'(src), 32'd0);
        chk("R1", "vld", 32'(vld), 32'd0);
        chk("R1", "out_l", 32'(ol), 32'd0);
        chk("R1", "out_r", 32'(orr), 32'd0);
      end else begin
        string tb_, tk_, tl_, tr_;
        tb_ = m_edge ? "R2" : (slv ? "R5" : "R3");
        tk_ = slv ? "R5" : "R4";
        chk(tb_, "busy", 32'(busy), 32'(m_cnt < cal_lim()));
        chk(tk_, "ok", 32'(ok), 32'(m_cnt >= val_lim()));
        chk("R9", "src", 32'(src), 32'(m_src));
        chk("R7", "vld", 32'(vld), 32'(m_vld));
        if (restart_run) begin
          tl_ = "R10"; tr_ = "R10";
        end else begin
          tl_ = m_sat_l ? "R8" : (m_cnt >= val_lim() ? "R6" : "R7");
          tr_ = m_sat_r ? "R8" : (m_cnt >= val_lim() ? "R6" : "R7");
        end
        chk(tl_, "out_l", 32'(ol), 32'(m_out_l[DW-1:0]));
        chk(tr_, "out_r", 32'(orr), 32'(m_out_r[DW-1:0]));
      end
    end
  end

  task automatic do_reset(input bit d, input bit s);
    @(posedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    dbl = d; slv = s;
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic run_frames(input int n);
    for (int f = 0; f < n; f++) begin
      for (int c = 0; c < FR; c++) begin
        @(posedge clk); #1;
        lrck = (c < FR / 2);
        stb  = (c == 4);
        if (c == 4) begin
          longint vl, vr;
          vl = base_l + (gk % 5) - 2;
          vr = base_r - (gk % 3);
          if (m_cnt > cal_lim() + 1 && (gk % 4) == 3) begin
            vl = ((gk % 8) == 3) ? PMAX : NMAX;
            vr = ((gk % 8) == 3) ? NMAX : PMAX;
          end
          sl = vl[DW-1:0];
          sr = vr[DW-1:0];
          if (zcal_toggle) zcal = ~zcal;
          gk++;
        end
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog run did not finish");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // Normal speed, master timing, negative left / positive right offset.
    zcal = 1'b1; base_l = -1000; base_r = 700;
    do_reset(1'b0, 1'b0);
    run_frames(VALF + 8);
    // Cut a window short, then restart with slave timing (R10).
    base_l = 3000; base_r = -2500;
    do_reset(1'b0, 1'b0);
    run_frames(20);
    restart_run = 1'b1; zcal_toggle = 1'b1;
    do_reset(1'b0, 1'b1);
    run_frames(6);
    restart_run = 1'b0;
    run_frames(VALF);
    zcal_toggle = 1'b0;
    // Double speed, master then slave.
    zcal = 1'b0; base_l = 5000; base_r = -3;
    do_reset(1'b1, 1'b0);
    run_frames(2 * VALF + 8);
    base_l = -20; base_r = 90000;
    do_reset(1'b1, 1'b1);
    run_frames(2 * VALF + 8);
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule